// File: doc/BRIEF.md
# Flash command interface state machine

This block sits behind the write path of a parallel NOR flash. It decodes each bus write as a command and keeps track of the device's command mode. Single-cycle codes take effect on their own. Two-cycle codes are held after their setup write. The following write either commits them with the matching confirm code or rejects them. The block drives the read mode that the data path must present: array, status, identifier or query. For each committed operation it gives a one-cycle start pulse, together with an operation kind, the address that operation targets, and the data of the write that triggered it.

An engine outside this block runs the embedded algorithms and reports activity on `busy_i`. While that engine runs, only the status-read and suspend codes are accepted. A suspended operation is resumed with the confirm code once the engine is idle. A status register collects sticky error flags: sequence error, lock-down violation and buffer abort. A dedicated clear code resets those flags.

Top module: `flash_cmd_fsm`

## Requirements
- R1: With `busy_i` low, a write of code FFh, 70h, 90h or 98h (low byte of `wr_data_i`) sets `rd_mode_o` to 0 (array), 1 (status), 2 (identifier) or 3 (query), starting in the cycle after the write.
- R2: Code 50h clears status bits 5 (lock error), 4 (sequence error) and 3 (buffer abort) in the cycle after the write. `status_o[7]` always equals the inverse of `busy_i`, and bits 2:0 read zero.
- R3: Code 40h arms a word program. The next write produces one start pulse of kind 1 carrying that write's address and data. Code C0h does the same with kind 12. Every start pulse lasts one cycle and appears in the cycle after the triggering write.
- R4: Setup codes 80h, 20h and BCh followed by D0h start kinds 3, 4 and 5 respectively. The pulse carries the setup write's address. Every setup code sets `rd_mode_o` to status.
- R5: Setup code 60h followed by 01h, D0h, 2Fh or 03h starts kind 8 (lock), 9 (unlock), 10 (lock-down) or 11 (configuration write) respectively, with the setup address.
- R6: A setup followed by any code other than one of its valid confirms sets status bit 4, starts nothing, and sets `rd_mode_o` to status. A D0h with no setup pending and nothing suspended does the same.
- R7: E8h (at a block address) is followed by a count write whose low 5 data bits hold N-1. Exactly N data writes follow, then D0h, which starts kind 2 with the E8h address.
- R8: During the count or data writes of a buffered program, a write whose address bits [15:12] differ from those of the E8h write aborts the program. It sets status bit 3, starts nothing and selects status mode. A following FFh returns to array mode, and the program must be restarted from E8h.
- R9: While `busy_i` is high, `rd_mode_o` reads status, and all writes other than 70h and B0h are ignored. They change neither the pending command state nor the mode seen after `busy_i` falls.
- R10: B0h while busy, with nothing already suspended, starts kind 6 and sets status bit 6. B0h while idle is ignored. D0h while suspended and idle starts kind 7 and clears bit 6.
- R11: A lock-down of a block (bits [15:12]) stays in force until reset. A later unlock of that block starts nothing and sets status bit 5.
- R12: Code EBh starts kind 13 (password access) with the write's address and selects status mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | One-cycle bus write strobe |
| wr_addr_i | input | ADDR_W | Write address; top BLK_W bits give the block |
| wr_data_i | input | DATA_W | Write data; low byte is the command code |
| busy_i | input | 1 | Embedded operation in progress |
| rd_mode_o | output | 2 | 0 array, 1 status, 2 identifier, 3 query |
| op_start_o | output | 1 | One-cycle start pulse |
| op_kind_o | output | 4 | Kind of the started operation |
| op_addr_o | output | ADDR_W | Target address of the started operation |
| op_data_o | output | DATA_W | Data of the triggering write |
| status_o | output | 8 | Ready, suspended, lock error, sequence error, abort, 3 zero bits |

## Verification
Every registered result is due exactly one clock after the edge that samples the write. That covers the start pulse with its kind, address and data, the read mode and the error and suspend bits. The ready bit and the busy override of the read mode follow `busy_i` in the same cycle. The bench drives inputs on the falling edge and advances its reference model on the rising edge. It compares every output 5 ns after that edge, so each result is checked in the first cycle it is due and in every later cycle. Ignored writes are shown at the ports: the mode and pending state that remain after busy drops are observed directly.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [1:0] {
    RM_ARRAY  = 2'd0,
    RM_STATUS = 2'd1,
    RM_IDENT  = 2'd2,
    RM_QUERY  = 2'd3
  } rd_mode_e;

  typedef enum logic [3:0] {
    OP_NONE     = 4'd0,
    OP_WORD_PGM = 4'd1,
    OP_BUF_PGM  = 4'd2,
    OP_EFP      = 4'd3,
    OP_ERASE    = 4'd4,
    OP_BLANK    = 4'd5,
    OP_SUSPEND  = 4'd6,
    OP_RESUME   = 4'd7,
    OP_LOCK     = 4'd8,
    OP_UNLOCK   = 4'd9,
    OP_LOCKDOWN = 4'd10,
    OP_CFG      = 4'd11,
    OP_OTP      = 4'd12,
    OP_PASSWORD = 4'd13
  } op_kind_e;

  typedef enum logic [3:0] {
    CMD_NONE, CMD_RD_ARRAY, CMD_RD_STATUS, CMD_RD_IDENT, CMD_RD_QUERY,
    CMD_CLR_STATUS, CMD_WORD_PGM, CMD_BUF_PGM, CMD_EFP, CMD_ERASE,
    CMD_BLANK, CMD_SETUP_SEC, CMD_SUSPEND, CMD_CONFIRM, CMD_OTP, CMD_PASSWORD
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WP_ARM, ST_OTP_ARM, ST_SETUP, ST_BUF_CNT, ST_BUF_LOAD, ST_BUF_CONF
  } fsm_st_e;

  // second codes after the security setup
  localparam logic [7:0] SUB_LOCK     = 8'h01;
  localparam logic [7:0] SUB_UNLOCK   = 8'hD0;
  localparam logic [7:0] SUB_LOCKDOWN = 8'h2F;
  localparam logic [7:0] SUB_CFG      = 8'h03;
  localparam logic [7:0] CODE_CONFIRM = 8'hD0;

  localparam int STS_READY    = 7;
  localparam int STS_SUSP     = 6;
  localparam int STS_LOCK_ERR = 5;
  localparam int STS_SEQ_ERR  = 4;
  localparam int STS_ABORT    = 3;

endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
  import flash_cmd_pkg::*;
(
  input  logic [7:0] code_i,
  output cmd_e       cmd_o
);
  always_comb begin
    unique case (code_i)
      8'hFF:   cmd_o = CMD_RD_ARRAY;
      8'h70:   cmd_o = CMD_RD_STATUS;
      8'h90:   cmd_o = CMD_RD_IDENT;
      8'h98:   cmd_o = CMD_RD_QUERY;
      8'h50:   cmd_o = CMD_CLR_STATUS;
      8'h40:   cmd_o = CMD_WORD_PGM;
      8'hE8:   cmd_o = CMD_BUF_PGM;
      8'h80:   cmd_o = CMD_EFP;
      8'h20:   cmd_o = CMD_ERASE;
      8'hBC:   cmd_o = CMD_BLANK;
      8'h60:   cmd_o = CMD_SETUP_SEC;
      8'hB0:   cmd_o = CMD_SUSPEND;
      8'hD0:   cmd_o = CMD_CONFIRM;
      8'hC0:   cmd_o = CMD_OTP;
      8'hEB:   cmd_o = CMD_PASSWORD;
      default: cmd_o = CMD_NONE;
    endcase
  end
endmodule

// File: rtl/flash_buf_tracker.sv
module flash_buf_tracker #(
  parameter int ADDR_W = 16,
  parameter int BLK_W  = 4,
  parameter int CNT_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              blk_cap_i,
  input  logic              cnt_ld_i,
  input  logic              cnt_dec_i,
  input  logic [CNT_W-1:0]  cnt_val_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              out_of_blk_o,
  output logic              last_o
);
  logic [BLK_W-1:0] blk_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blk_q <= '0;
      cnt_q <= '0;
    end else begin
      if (blk_cap_i) blk_q <= addr_i[ADDR_W-1 -: BLK_W];
      if (cnt_ld_i)       cnt_q <= cnt_val_i;
      else if (cnt_dec_i) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign out_of_blk_o = addr_i[ADDR_W-1 -: BLK_W] != blk_q;
  assign last_o       = cnt_q == '0;
endmodule

// File: rtl/flash_lock_table.sv
module flash_lock_table #(
  parameter int NUM_BLK = 16,
  localparam int IDX_W  = $clog2(NUM_BLK)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               set_i,
  input  logic [IDX_W-1:0]   idx_i,
  output logic               locked_o,
  output logic [NUM_BLK-1:0] ld_o
);
  for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                ld_o[b] <= 1'b0;
      else if (set_i && idx_i == IDX_W'(b))       ld_o[b] <= 1'b1;
    end
  end

  assign locked_o = ld_o[idx_i];
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter int BLK_W     = 4,
  parameter int BUF_WORDS = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              busy_i,
  output logic [1:0]        rd_mode_o,
  output logic              op_start_o,
  output logic [3:0]        op_kind_o,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic [DATA_W-1:0] op_data_o,
  output logic [7:0]        status_o
);
  localparam int NUM_BLK = 1 << BLK_W;
  localparam int CNT_W   = $clog2(BUF_WORDS);

  fsm_st_e           st_q, st_d;
  rd_mode_e          mode_q, mode_d;
  cmd_e              setup_q, setup_d, cmd;
  logic [ADDR_W-1:0] saddr_q, saddr_d;
  logic              susp_q, susp_d, lk_q, lk_d, seq_q, seq_d, ab_q, ab_d;
  logic              start_q, start_d;
  op_kind_e          kind_q, kind_d;
  logic [ADDR_W-1:0] oaddr_q, oaddr_d;
  logic [DATA_W-1:0] odata_q, odata_d;
  logic              blk_cap, cnt_ld, cnt_dec, out_of_blk, cnt_last;
  logic              ld_set, blk_locked;
  logic [NUM_BLK-1:0] ld_vec;
  logic [7:0]        code;

  assign code = wr_data_i[7:0];

  flash_cmd_decode i_decode (.code_i(code), .cmd_o(cmd));

  flash_buf_tracker #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .CNT_W(CNT_W)) i_buf (
    .clk_i, .rst_ni,
    .blk_cap_i   (blk_cap),
    .cnt_ld_i    (cnt_ld),
    .cnt_dec_i   (cnt_dec),
    .cnt_val_i   (wr_data_i[CNT_W-1:0]),
    .addr_i      (wr_addr_i),
    .out_of_blk_o(out_of_blk),
    .last_o      (cnt_last)
  );

  flash_lock_table #(.NUM_BLK(NUM_BLK)) i_lock (
    .clk_i, .rst_ni,
    .set_i   (ld_set),
    .idx_i   (saddr_q[ADDR_W-1 -: BLK_W]),
    .locked_o(blk_locked),
    .ld_o    (ld_vec)
  );

  always_comb begin
    st_d    = st_q;
    mode_d  = mode_q;
    setup_d = setup_q;
    saddr_d = saddr_q;
    susp_d  = susp_q;
    lk_d    = lk_q;
    seq_d   = seq_q;
    ab_d    = ab_q;
    start_d = 1'b0;
    kind_d  = OP_NONE;
    oaddr_d = oaddr_q;
    odata_d = odata_q;
    blk_cap = 1'b0;
    cnt_ld  = 1'b0;
    cnt_dec = 1'b0;
    ld_set  = 1'b0;

    if (wr_en_i && busy_i) begin
      if (cmd == CMD_RD_STATUS) begin
        mode_d = RM_STATUS;
      end else if (cmd == CMD_SUSPEND && !susp_q) begin
        susp_d  = 1'b1;
        start_d = 1'b1;
        kind_d  = OP_SUSPEND;
        oaddr_d = wr_addr_i;
        odata_d = wr_data_i;
      end
    end else if (wr_en_i) begin
      unique case (st_q)
        ST_IDLE: begin
          unique case (cmd)
            CMD_RD_ARRAY:  mode_d = RM_ARRAY;
            CMD_RD_STATUS: mode_d = RM_STATUS;
            CMD_RD_IDENT:  mode_d = RM_IDENT;
            CMD_RD_QUERY:  mode_d = RM_QUERY;
            CMD_CLR_STATUS: begin
              lk_d  = 1'b0;
              seq_d = 1'b0;
              ab_d  = 1'b0;
            end
            CMD_WORD_PGM: begin
              st_d   = ST_WP_ARM;
              mode_d = RM_STATUS;
            end
            CMD_OTP: begin
              st_d   = ST_OTP_ARM;
              mode_d = RM_STATUS;
            end
            CMD_BUF_PGM: begin
              st_d    = ST_BUF_CNT;
              mode_d  = RM_STATUS;
              saddr_d = wr_addr_i;
              blk_cap = 1'b1;
            end
            CMD_EFP, CMD_ERASE, CMD_BLANK, CMD_SETUP_SEC: begin
              st_d    = ST_SETUP;
              mode_d  = RM_STATUS;
              setup_d = cmd;
              saddr_d = wr_addr_i;
            end
            CMD_CONFIRM: begin
              mode_d = RM_STATUS;
              if (susp_q) begin
                susp_d  = 1'b0;
                start_d = 1'b1;
                kind_d  = OP_RESUME;
                oaddr_d = wr_addr_i;
                odata_d = wr_data_i;
              end else begin
                seq_d = 1'b1;
              end
            end
            CMD_PASSWORD: begin
              mode_d  = RM_STATUS;
              start_d = 1'b1;
              kind_d  = OP_PASSWORD;
              oaddr_d = wr_addr_i;
              odata_d = wr_data_i;
            end
            default: ;
          endcase
        end

        ST_WP_ARM, ST_OTP_ARM: begin
          st_d    = ST_IDLE;
          start_d = 1'b1;
          kind_d  = (st_q == ST_WP_ARM) ? OP_WORD_PGM : OP_OTP;
          oaddr_d = wr_addr_i;
          odata_d = wr_data_i;
        end

        ST_SETUP: begin
          st_d    = ST_IDLE;
          mode_d  = RM_STATUS;
          oaddr_d = saddr_q;
          odata_d = wr_data_i;
          if (setup_q == CMD_SETUP_SEC) begin
            unique case (code)
              SUB_LOCK:     begin start_d = 1'b1; kind_d = OP_LOCK; end
              SUB_LOCKDOWN: begin start_d = 1'b1; kind_d = OP_LOCKDOWN; ld_set = 1'b1; end
              SUB_CFG:      begin start_d = 1'b1; kind_d = OP_CFG; end
              SUB_UNLOCK: begin
                if (blk_locked) lk_d = 1'b1;
                else begin start_d = 1'b1; kind_d = OP_UNLOCK; end
              end
              default:      seq_d = 1'b1;
            endcase
          end else if (code == CODE_CONFIRM) begin
            start_d = 1'b1;
            unique case (setup_q)
              CMD_EFP:   kind_d = OP_EFP;
              CMD_ERASE: kind_d = OP_ERASE;
              default:   kind_d = OP_BLANK;
            endcase
          end else begin
            seq_d = 1'b1;
          end
          if (!start_d) begin
            oaddr_d = oaddr_q;
            odata_d = odata_q;
          end
        end

        ST_BUF_CNT, ST_BUF_LOAD: begin
          if (out_of_blk) begin
            st_d   = ST_IDLE;
            mode_d = RM_STATUS;
            ab_d   = 1'b1;
          end else if (st_q == ST_BUF_CNT) begin
            st_d   = ST_BUF_LOAD;
            cnt_ld = 1'b1;
          end else if (cnt_last) begin
            st_d = ST_BUF_CONF;
          end else begin
            cnt_dec = 1'b1;
          end
        end

        ST_BUF_CONF: begin
          st_d   = ST_IDLE;
          mode_d = RM_STATUS;
          if (code == CODE_CONFIRM) begin
            start_d = 1'b1;
            kind_d  = OP_BUF_PGM;
            oaddr_d = saddr_q;
            odata_d = wr_data_i;
          end else begin
            seq_d = 1'b1;
          end
        end

        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      mode_q  <= RM_ARRAY;
      setup_q <= CMD_NONE;
      saddr_q <= '0;
      susp_q  <= 1'b0;
      lk_q    <= 1'b0;
      seq_q   <= 1'b0;
      ab_q    <= 1'b0;
      start_q <= 1'b0;
      kind_q  <= OP_NONE;
      oaddr_q <= '0;
      odata_q <= '0;
    end else begin
      st_q    <= st_d;
      mode_q  <= mode_d;
      setup_q <= setup_d;
      saddr_q <= saddr_d;
      susp_q  <= susp_d;
      lk_q    <= lk_d;
      seq_q   <= seq_d;
      ab_q    <= ab_d;
      start_q <= start_d;
      kind_q  <= kind_d;
      oaddr_q <= oaddr_d;
      odata_q <= odata_d;
    end
  end

  // engine activity overrides the visible read mode
  assign rd_mode_o  = busy_i ? RM_STATUS : mode_q;
  assign op_start_o = start_q;
  assign op_kind_o  = kind_q;
  assign op_addr_o  = oaddr_q;
  assign op_data_o  = odata_q;
  assign status_o   = {~busy_i, susp_q, lk_q, seq_q, ab_q, 3'b000};

endmodule

// File: rtl/flash_cmd_fsm_chk.sv
module flash_cmd_fsm_chk #(
  parameter int NUM_BLK = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic [7:0]         code_i,
  input logic               busy_i,
  input logic [1:0]         rd_mode_o,
  input logic               op_start_o,
  input logic [3:0]         op_kind_o,
  input logic [7:0]         status_o,
  input logic [NUM_BLK-1:0] ld_i
);
  p_pulse_needs_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_start_o |-> $past(wr_en_i));

  p_kind_valid_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_start_o |-> op_kind_o != 4'd0);

  p_seq_err_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[4]) |-> !op_start_o && rd_mode_o == 2'd1);

  p_abort_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[3]) |-> !op_start_o);

  p_busy_ignore_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && wr_en_i && code_i != 8'hB0 |=> !op_start_o);

  p_suspend_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[6]) |-> op_start_o && op_kind_o == 4'd6);

  p_resume_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(status_o[6]) |-> op_start_o && op_kind_o == 4'd7);

  p_lockdown_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(ld_i) & ~ld_i) == '0);

  p_lock_err_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[5]) |-> !op_start_o);
endmodule

bind flash_cmd_fsm flash_cmd_fsm_chk #(.NUM_BLK(NUM_BLK)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .code_i    (wr_data_i[7:0]),
  .busy_i    (busy_i),
  .rd_mode_o (rd_mode_o),
  .op_start_o(op_start_o),
  .op_kind_o (op_kind_o),
  .status_o  (status_o),
  .ld_i      (ld_vec)
);

// File: tb/test_flash_cmd_fsm.sv
module test_flash_cmd_fsm;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        busy = 1'b0;
  logic [1:0]  rd_mode;
  logic        op_start;
  logic [3:0]  op_kind;
  logic [15:0] op_addr;
  logic [15:0] op_data;
  logic [7:0]  status;

  int checks = 0;
  int fails  = 0;

  flash_cmd_fsm i_flash_cmd_fsm (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .busy_i(busy), .rd_mode_o(rd_mode),
    .op_start_o(op_start), .op_kind_o(op_kind), .op_addr_o(op_addr),
    .op_data_o(op_data), .status_o(status)
  );

  always #10 clk = ~clk;

  // reference model state
  int m_st, m_setup, m_saddr, m_cnt, m_mode;
  bit m_susp, m_lk, m_seq, m_ab, m_start;
  int m_kind, m_addr, m_data;
  bit m_ld[16];

  task automatic m_pulse(int k, int a, int d);
    m_start = 1; m_kind = k; m_addr = a; m_data = d;
  endtask

  task automatic m_reset();
    m_st = 0; m_setup = 0; m_saddr = 0; m_cnt = 0; m_mode = 0;
    m_susp = 0; m_lk = 0; m_seq = 0; m_ab = 0; m_start = 0;
    m_kind = 0; m_addr = 0; m_data = 0;
    foreach (m_ld[i]) m_ld[i] = 0;
  endtask

  // states: 0 idle, 1 word arm, 2 otp arm, 3 setup, 4 count, 5 load, 6 confirm
  task automatic m_step();
    int c, a, d;
    c = int'(wr_data[7:0]); a = int'(wr_addr); d = int'(wr_data);
    m_start = 0;
    if (!wr_en) return;
    if (busy) begin
      if (c == 'h70) m_mode = 1;
      else if (c == 'hB0 && !m_susp) begin m_susp = 1; m_pulse(6, a, d); end
      return;
    end
    case (m_st)
      0: case (c)
        'hFF: m_mode = 0;
        'h70: m_mode = 1;
        'h90: m_mode = 2;
        'h98: m_mode = 3;
        'h50: begin m_lk = 0; m_seq = 0; m_ab = 0; end
        'h40: begin m_st = 1; m_mode = 1; end
        'hC0: begin m_st = 2; m_mode = 1; end
        'hE8: begin m_st = 4; m_mode = 1; m_saddr = a; end
        'h80, 'h20, 'hBC, 'h60: begin m_st = 3; m_mode = 1; m_setup = c; m_saddr = a; end
        'hD0: begin
          m_mode = 1;
          if (m_susp) begin m_susp = 0; m_pulse(7, a, d); end
          else m_seq = 1;
        end
        'hEB: begin m_mode = 1; m_pulse(13, a, d); end
        default: ;
      endcase
      1: begin m_st = 0; m_pulse(1, a, d); end
      2: begin m_st = 0; m_pulse(12, a, d); end
      3: begin
        m_st = 0; m_mode = 1;
        if (m_setup == 'h60) begin
          if (c == 'h01) m_pulse(8, m_saddr, d);
          else if (c == 'h2F) begin m_pulse(10, m_saddr, d); m_ld[m_saddr >> 12] = 1; end
          else if (c == 'h03) m_pulse(11, m_saddr, d);
          else if (c == 'hD0) begin
            if (m_ld[m_saddr >> 12]) m_lk = 1; else m_pulse(9, m_saddr, d);
          end else m_seq = 1;
        end else if (c == 'hD0)
          m_pulse(m_setup == 'h80 ? 3 : m_setup == 'h20 ? 4 : 5, m_saddr, d);
        else m_seq = 1;
      end
      4, 5: begin
        if ((a >> 12) != (m_saddr >> 12)) begin m_st = 0; m_mode = 1; m_ab = 1; end
        else if (m_st == 4) begin m_st = 5; m_cnt = (d & 31) + 1; end
        else begin m_cnt--; if (m_cnt == 0) m_st = 6; end
      end
      default: begin
        m_st = 0; m_mode = 1;
        if (c == 'hD0) m_pulse(2, m_saddr, d); else m_seq = 1;
      end
    endcase
  endtask

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    int exp_mode, exp_sts;
    exp_mode = busy ? 1 : m_mode;
    exp_sts  = {!busy, m_susp, m_lk, m_seq, m_ab, 3'b000};
    chk(int'(rd_mode) == exp_mode, "R1", "rd_mode", int'(rd_mode), exp_mode);
    chk(int'(status) == exp_sts, "R2", "status", int'(status), exp_sts);
    chk(op_start == m_start, "R3", "op_start", int'(op_start), int'(m_start));
    if (m_start && op_start) begin
      chk(int'(op_kind) == m_kind, "R4", "op_kind", int'(op_kind), m_kind);
      chk(int'(op_addr) == m_addr, "R5", "op_addr", int'(op_addr), m_addr);
      chk(int'(op_data) == m_data, "R3", "op_data", int'(op_data), m_data);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) m_reset();
    else m_step();
    #5 if (rst_n) compare();
  end

  task automatic wr(logic [15:0] d, logic [15:0] a);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; wr_addr = a;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_busy(bit b);
    @(negedge clk);
    busy = b;
  endtask

  bit done = 0;

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    m_reset();
    repeat (3) @(negedge clk);
    // reset state
    chk(rd_mode == 2'd0, "R1", "reset rd_mode", int'(rd_mode), 0);
    chk(status == 8'h80, "R2", "reset status", int'(status), 'h80);
    chk(op_start == 1'b0, "R3", "reset op_start", int'(op_start), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 read modes
    wr(16'h0090, 16'h0000); wr(16'h0098, 16'h0000);
    wr(16'h0070, 16'h0000); wr(16'h00FF, 16'h0000);
    // R3 word program and OTP write
    wr(16'h0040, 16'h1000); wr(16'hA55A, 16'h1234);
    wr(16'h00C0, 16'h0000); wr(16'h5AA5, 16'h0081);
    // R4 two-cycle operations
    wr(16'h0020, 16'h2000); wr(16'h00D0, 16'h2000);
    wr(16'h0080, 16'h4000); wr(16'h00D0, 16'h4000);
    wr(16'h00BC, 16'h5000); wr(16'h00D0, 16'h5000);
    // R5 security setup variants
    wr(16'h0060, 16'h6000); wr(16'h0001, 16'h6000);
    wr(16'h0060, 16'h6000); wr(16'h00D0, 16'h6000);
    wr(16'h0060, 16'h0000); wr(16'h0003, 16'h0000);
    // R11 lock-down then refused unlock, other block still unlockable
    wr(16'h0060, 16'h3000); wr(16'h002F, 16'h3000);
    wr(16'h0060, 16'h3010); wr(16'h00D0, 16'h3010);
    wr(16'h0050, 16'h0000);
    wr(16'h0060, 16'h7000); wr(16'h00D0, 16'h7000);
    // R6 wrong confirm and lone confirm
    wr(16'h0020, 16'h2000); wr(16'h0055, 16'h2000);
    wr(16'h00FF, 16'h0000);
    wr(16'h0060, 16'h2000); wr(16'h0077, 16'h2000);
    wr(16'h0050, 16'h0000);
    wr(16'h00D0, 16'h0000);
    wr(16'h0050, 16'h0000);
    // R7 buffered program with four words
    wr(16'h00E8, 16'h8000); wr(16'h0003, 16'h8000);
    for (int i = 0; i < 4; i++) wr(16'h00D0 + 16'(i), 16'h8000 + 16'(i));
    wr(16'h00D0, 16'h8000);
    // R7 boundary: single word, then wrong confirm
    wr(16'h00E8, 16'h9000); wr(16'h0000, 16'h9000);
    wr(16'h1111, 16'h9002); wr(16'h0000, 16'h9000);
    wr(16'h0050, 16'h0000);
    // R7 boundary: full buffer of 32 words
    wr(16'h00E8, 16'hA000); wr(16'h001F, 16'hA000);
    for (int i = 0; i < 32; i++) wr(16'(i * 3), 16'hA000 + 16'(i));
    wr(16'h00D0, 16'hA000);
    // R8 abort during load, then return to array and restart
    wr(16'h00E8, 16'hB000); wr(16'h0002, 16'hB000);
    wr(16'h2222, 16'hB001); wr(16'h3333, 16'hC001);
    wr(16'h00FF, 16'h0000);
    wr(16'h00E8, 16'hB000); wr(16'h0000, 16'hB000);
    wr(16'h4444, 16'hB004); wr(16'h00D0, 16'hB000);
    // R8 abort on the count write
    wr(16'h00E8, 16'hB000); wr(16'h0001, 16'hD000);
    wr(16'h0050, 16'h0000);
    // R9 writes ignored while busy, mode kept
    wr(16'h00FF, 16'h0000);
    set_busy(1);
    wr(16'h0090, 16'h0000);
    wr(16'h0020, 16'h2000);
    set_busy(0);
    repeat (2) @(negedge clk);
    wr(16'h00D0, 16'h2000);
    wr(16'h0050, 16'h0000);
    // R10 suspend while busy, resume when idle, B0h when idle ignored
    wr(16'h00B0, 16'h0000);
    set_busy(1);
    wr(16'h00B0, 16'h2000);
    wr(16'h0070, 16'h0000);
    wr(16'h00B0, 16'h2000);
    set_busy(0);
    wr(16'h0098, 16'h0000);
    wr(16'h00D0, 16'h2000);
    // R12 password access
    wr(16'h00FF, 16'h0000);
    wr(16'h00EB, 16'hE000);
    repeat (3) @(negedge clk);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule